// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block sits between a group of sixteen parallel lanes and a word-addressed scratchpad. The scratchpad is split into sixteen single-port banks, each 32 bits wide. A requester presents one group of up to sixteen lane requests in a single cycle. Each request carries an enable bit, a word address, a write flag and write data. The block latches the group and splits it into rounds in which no bank sees more than one distinct word. It raises a stall while it works through those rounds. When every lane has been served it pulses a completion flag, and all per-lane read results are ready in that same cycle.

Bank selection uses the low four bits of the word address, so neighbouring words fall in neighbouring banks. In each round, every bank serves the word wanted by its lowest-numbered pending lane. All pending lanes that want that same word are served together, so a single read is broadcast to all of them. The number of rounds in a group is therefore the largest count of distinct words that the group requests from any one bank.

Top module: `bank_conflict_arbiter`

## Requirements
- R1: The bank of a request is its word address modulo 16 (address bits 3:0). Two lanes whose addresses differ only above bit 3 share a bank. Addresses that differ in bits 3:0 never share a bank.
- R2: A group in which all active lanes hit different banks completes in one round.
- R3: Lanes that read the identical word in one group are served in a single access. They all return that word, and they add no round.
- R4: Lanes that hit one bank at different words are served in separate rounds. Each distinct word in a bank costs one round.
- R5: The round count of a group equals the largest number of distinct words requested from any single bank. Sixteen lanes at address stride 2 take 2 rounds, stride 4 takes 4, stride 8 takes 8 and stride 16 takes 16.
- R6: When several lanes write the same word in one group, the highest-numbered lane's data is stored.
- R7: A read and a write of the same word in one group are served in the same round. The read returns the value the word held before the group.
- R8: When done is high, rd_data holds the result of every active lane. Lanes that were inactive in the group read zero. The outputs then hold until the next group is accepted.
- R9: A group is accepted on a clock edge where start is high and stall is low. Stall is high in each round cycle after that edge. Done is a single-cycle pulse on the cycle after the last round, with stall low.
- R10: While stall is high, start and all lane inputs are ignored. The group in flight completes with its original addresses, data and round count.
- R11: A group with no active lanes takes exactly one round and then pulses done.
- R12: After reset, stall and done are low and rd_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Present a new group (accepted while stall is low) |
| lane_act | input | 16 | Per-lane request enable |
| lane_addr | input | 128 | Per-lane 8-bit word address, lane i in bits [8i+7:8i] |
| lane_we | input | 16 | Per-lane write flag (1 = write, 0 = read) |
| lane_wdata | input | 512 | Per-lane write word, lane i in bits [32i+31:32i] |
| stall | output | 1 | Group in progress; the requester must wait |
| done | output | 1 | One-cycle pulse: every lane of the group has been served |
| rd_data | output | 512 | Per-lane read word, lane i in bits [32i+31:32i] |

## Verification
The assertions assume that the requester holds no expectation of the inputs while stall is high. They also assume that a group, once accepted, is owned entirely by the block, so the pending set may only shrink and must shrink every round. The stimulus honours this by pulsing start only on cycles where stall is low, except for one deliberate pulse during a long group that tests R10. The bench reads no word before it has written that word, so every read value follows from earlier writes.

// File: rtl/bank_arb_pkg.sv
package bank_arb_pkg;
  localparam int LANES     = 16;
  localparam int BANK_BITS = 4;
  localparam int NBANKS    = 1 << BANK_BITS;
  localparam int WORD_W    = 32;

  // bank index of a word address: low bits of the address
  function automatic logic [BANK_BITS-1:0] bank_of(input logic [15:0] a);
    return a[BANK_BITS-1:0];
  endfunction

  // row inside a bank: the address bits above the bank field
  function automatic logic [11:0] row_of(input logic [15:0] a);
    return a[15:BANK_BITS];
  endfunction
endpackage

// File: rtl/bank_pick.sv
module bank_pick
  import bank_arb_pkg::*;
#(
  parameter int N    = LANES,
  parameter int AW   = 8,
  parameter int W    = WORD_W,
  parameter int BANK = 0
) (
  input  logic [N-1:0]         pend,
  input  logic [N-1:0][AW-1:0] addr,
  input  logic [N-1:0]         we,
  input  logic [N-1:0][W-1:0]  wdata,
  output logic [N-1:0]         serve,
  output logic                 any,
  output logic [AW-1:0]        lead_addr,
  output logic                 wr_en,
  output logic [W-1:0]         wr_data
);
  logic [N-1:0] cand;

  always_comb begin
    cand      = '0;
    any       = 1'b0;
    lead_addr = '0;
    for (int i = 0; i < N; i++) begin
      cand[i] = pend[i] && (bank_of(16'(addr[i])) == BANK_BITS'(BANK));
    end
    // leader: lowest-numbered pending lane of this bank
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        any       = 1'b1;
        lead_addr = addr[i];
      end
    end
    serve   = '0;
    wr_en   = 1'b0;
    wr_data = '0;
    for (int i = 0; i < N; i++) begin
      serve[i] = cand[i] && (addr[i] == lead_addr);
      // ascending scan: the last writer seen (highest lane) wins
      if (serve[i] && we[i]) begin
        wr_en   = 1'b1;
        wr_data = wdata[i];
      end
    end
  end
endmodule

// File: rtl/bank_ram.sv
module bank_ram #(
  parameter int ROWS = 16,
  parameter int W    = 32,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [ROWS];

  // read-first: rdata shows the stored word before this cycle's write
  assign rdata = mem[row];

  always_ff @(posedge clk) begin
    if (en && we) mem[row] <= wdata;
  end
endmodule

// File: rtl/bank_conflict_arbiter.sv
module bank_conflict_arbiter
  import bank_arb_pkg::*;
#(
  parameter int ROWS = 16,
  localparam int RB  = $clog2(ROWS),
  localparam int AW  = BANK_BITS + RB,
  localparam int CW  = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [LANES-1:0]        lane_act,
  input  logic [LANES*AW-1:0]     lane_addr,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*WORD_W-1:0] lane_wdata,
  output logic                    stall,
  output logic                    done,
  output logic [LANES*WORD_W-1:0] rd_data
);
  logic                           busy;
  logic [LANES-1:0]               pend;
  logic [LANES-1:0][AW-1:0]       a_q;
  logic [LANES-1:0]               we_q;
  logic [LANES-1:0][WORD_W-1:0]   wd_q;
  logic [LANES-1:0][WORD_W-1:0]   rd_q;
  logic [CW-1:0]                  rnd_cnt;

  logic [NBANKS-1:0][LANES-1:0]   serve_b;
  logic [NBANKS-1:0]              any_b;
  logic [NBANKS-1:0][AW-1:0]      lead_b;
  logic [NBANKS-1:0]              wen_b;
  logic [NBANKS-1:0][WORD_W-1:0]  wdat_b;
  logic [NBANKS-1:0][WORD_W-1:0]  rdat_b;

  // named events for the checks below
  logic             accept;
  logic             last_round;
  logic [LANES-1:0] serve_all;
  logic [LANES-1:0] pend_next;

  genvar b;
  generate
    for (b = 0; b < NBANKS; b++) begin : g_bank
      bank_pick #(.N(LANES), .AW(AW), .W(WORD_W), .BANK(b)) u_pick (
        .pend      (pend),
        .addr      (a_q),
        .we        (we_q),
        .wdata     (wd_q),
        .serve     (serve_b[b]),
        .any       (any_b[b]),
        .lead_addr (lead_b[b]),
        .wr_en     (wen_b[b]),
        .wr_data   (wdat_b[b])
      );
      bank_ram #(.ROWS(ROWS), .W(WORD_W)) u_ram (
        .clk   (clk),
        .en    (busy && any_b[b]),
        .we    (wen_b[b]),
        .row   (lead_b[b][AW-1:BANK_BITS]),
        .wdata (wdat_b[b]),
        .rdata (rdat_b[b])
      );
    end
  endgenerate

  always_comb begin
    serve_all = '0;
    for (int k = 0; k < NBANKS; k++) serve_all = serve_all | serve_b[k];
  end

  assign accept     = start && !busy;
  assign pend_next  = pend & ~serve_all;
  assign last_round = busy && (pend_next == '0);
  assign stall      = busy;
  assign rd_data    = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      pend    <= '0;
      a_q     <= '0;
      we_q    <= '0;
      wd_q    <= '0;
      rd_q    <= '0;
      rnd_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        pend    <= lane_act;
        a_q     <= lane_addr;
        we_q    <= lane_we;
        wd_q    <= lane_wdata;
        rd_q    <= '0;
        rnd_cnt <= '0;
      end else if (busy) begin
        for (int i = 0; i < LANES; i++) begin
          if (serve_all[i]) rd_q[i] <= rdat_b[bank_of(16'(a_q[i]))];
        end
        pend    <= pend_next;
        rnd_cnt <= rnd_cnt + 1'b1;
        if (last_round) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // every round retires at least one pending lane
  assert_progress_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pend != '0) |=> (pend != $past(pend)));

  // no lane rejoins the pending set while a group is in flight
  assert_no_regrow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((pend & ~$past(pend)) == '0));

  // a group never needs more rounds than lanes
  assert_round_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rnd_cnt < CW'(LANES)));

  // done is a lone pulse with stall low
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!stall ##1 !done));

  // results hold between groups
  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(rd_data));
endmodule

// File: tb/sim_bank_conflict_arbiter.sv
`timescale 1ns/1ps
module sim_bank_conflict_arbiter;
  localparam int L  = 16;
  localparam int AW = 8;
  localparam int NV = 8;
  // vector table: stride, base, expected rounds
  localparam int VSTR [NV] = '{1, 2, 8, 16, 0, 3, 4, 5};
  localparam int VBASE[NV] = '{0, 1, 7, 3, 42, 9, 2, 100};
  localparam int VCYC [NV] = '{1, 2, 8, 16, 1, 1, 4, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [L-1:0] lane_act = '0;
  logic [L*AW-1:0] lane_addr = '0;
  logic [L-1:0] lane_we = '0;
  logic [L*32-1:0] lane_wdata = '0;
  logic stall, done;
  logic [L*32-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mdl [256];
  logic [7:0]  ad [L];
  logic [31:0] wd [L];
  logic [31:0] exp_rd [L];

  always #5 clk = ~clk;

  bank_conflict_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_act(lane_act),
    .lane_addr(lane_addr), .lane_we(lane_we), .lane_wdata(lane_wdata),
    .stall(stall), .done(done), .rd_data(rd_data));

  function automatic logic [31:0] pat(input int a, input int salt);
    return 32'h9E3779B9 * (a + 1) ^ (salt * 32'h01010101);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // run one group; reads expected from the model before writes apply
  task automatic run_group(input logic [L-1:0] act, input logic [L-1:0] we,
                           input bit poke, output int cyc);
    for (int i = 0; i < L; i++) begin
      exp_rd[i] = act[i] ? mdl[ad[i]] : 32'h0;
      lane_addr[i*AW +: AW] = ad[i];
      lane_wdata[i*32 +: 32] = wd[i];
    end
    lane_act = act; lane_we = we; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done) begin
      if (stall) cyc++;
      if (poke && cyc == 2) begin
        start = 1'b1; lane_act = '1; lane_we = '1;
        lane_addr = '0; lane_wdata = '1;
      end else begin
        start = 1'b0;
      end
      if (cyc > 100) begin
        chk(1'b0, "watchdog", 32'(cyc), 32'd100);
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
    for (int i = 0; i < L; i++)
      if (act[i] && we[i]) mdl[ad[i]] = wd[i];
  endtask

  task automatic chk_reads(input string req);
    for (int i = 0; i < L; i++)
      chk(rd_data[i*32 +: 32] === exp_rd[i], req, rd_data[i*32 +: 32], exp_rd[i]);
  endtask

  initial begin
    #1ms;
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cyc;
    for (int a = 0; a < 256; a++) mdl[a] = 32'h0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(stall === 1'b0, "R12 stall", 32'(stall), 32'd0);
    chk(done === 1'b0, "R12 done", 32'(done), 32'd0);
    chk(rd_data === '0, "R12 rd_data", rd_data[31:0], 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // fill every word, one bank-parallel write group per row (R2)
    for (int r = 0; r < 16; r++) begin
      for (int i = 0; i < L; i++) begin
        ad[i] = 8'(16 * r + i); wd[i] = pat(16 * r + i, 0);
      end
      run_group('1, '1, 1'b0, cyc);
      chk(cyc == 1, "R2 fill rounds", 32'(cyc), 32'd1);
    end

    // vector table walk (R5, R3, R2)
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < L; i++) begin
        ad[i] = 8'(VBASE[v] + i * VSTR[v]); wd[i] = '0;
      end
      run_group('1, '0, 1'b0, cyc);
      chk(cyc == VCYC[v], "R5 rounds per stride", 32'(cyc), 32'(VCYC[v]));
      chk_reads("R3 R8 table reads");
    end

    // R1: address 3 and 19 share a bank, 3 and 20 do not
    for (int i = 0; i < L; i++) begin ad[i] = '0; wd[i] = '0; end
    ad[0] = 8'd3; ad[1] = 8'd19;
    run_group(16'h0003, '0, 1'b0, cyc);
    chk(cyc == 2, "R1 same bank", 32'(cyc), 32'd2);
    ad[1] = 8'd20;
    run_group(16'h0003, '0, 1'b0, cyc);
    chk(cyc == 1, "R1 other bank", 32'(cyc), 32'd1);

    // R3 + R4: lanes 0,1 broadcast word 2, lane 2 word 18 in same bank
    ad[0] = 8'd2; ad[1] = 8'd2; ad[2] = 8'd18;
    run_group(16'h0007, '0, 1'b0, cyc);
    chk(cyc == 2, "R4 serialize", 32'(cyc), 32'd2);
    chk_reads("R3 broadcast");
    chk(rd_data[5*32 +: 32] === 32'h0, "R8 inactive lane zero", rd_data[5*32 +: 32], 32'h0);

    // R6: lanes 3, 7, 12 write word 5
    for (int i = 0; i < L; i++) begin ad[i] = 8'd5; wd[i] = pat(i, 7); end
    run_group(16'h1088, 16'h1088, 1'b0, cyc);
    chk(cyc == 1, "R6 rounds", 32'(cyc), 32'd1);
    ad[0] = 8'd5;
    run_group(16'h0001, '0, 1'b0, cyc);
    chk(rd_data[31:0] === pat(12, 7), "R6 highest lane wins", rd_data[31:0], pat(12, 7));

    // R7: lane 0 reads word 9 while lane 1 writes it
    ad[0] = 8'd9; ad[1] = 8'd9; wd[1] = 32'hCAFE_F00D;
    run_group(16'h0003, 16'h0002, 1'b0, cyc);
    chk(cyc == 1, "R7 rounds", 32'(cyc), 32'd1);
    chk_reads("R7 read-first");
    run_group(16'h0001, '0, 1'b0, cyc);
    chk(rd_data[31:0] === 32'hCAFE_F00D, "R7 write landed", rd_data[31:0], 32'hCAFE_F00D);

    // R10: start pulse with new inputs during a stride-8 group
    for (int i = 0; i < L; i++) begin ad[i] = 8'(7 + 8 * i); wd[i] = '0; end
    run_group('1, '0, 1'b1, cyc);
    chk(cyc == 8, "R10 rounds unchanged", 32'(cyc), 32'd8);
    chk_reads("R10 reads unchanged");
    // nothing was written by the ignored pulse: word 0 keeps its value
    ad[0] = 8'd0;
    run_group(16'h0001, '0, 1'b0, cyc);
    chk(rd_data[31:0] === mdl[0], "R10 no write", rd_data[31:0], mdl[0]);

    // R11: empty group
    run_group('0, '0, 1'b0, cyc);
    chk(cyc == 1, "R11 empty group", 32'(cyc), 32'd1);
    chk(rd_data === '0, "R8 empty reads zero", rd_data[31:0], 32'h0);

    // R9: done lasts one cycle, stall low while idle; R8 outputs hold
    chk(done === 1'b1 && stall === 1'b0, "R9 done with stall low", {30'd0, done, stall}, 32'd2);
    @(negedge clk);
    chk(done === 1'b0, "R9 done pulse", 32'(done), 32'd0);
    chk(rd_data === '0, "R8 hold", rd_data[31:0], 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule